// File: doc/BRIEF.md
# ECC Syndrome DIMM Locator

This block takes the syndrome code that an ECC decoder reports for a memory error, together with the faulting physical address and the decode result for the bank that address hit. It works out which bit of a 576-bit cache-line transfer failed, which DIMM holds that bit, and which connector pin carries it. A 64-byte line crosses the bus as four beats of 144 bits. The beat comes from address bits [5:4]. The syndrome code is first converted into bus bit order, and the result indexes two lookup tables. One is a DIMM map that packs one 2-bit entry per line bit. The other is a pin map with one byte per line bit.

Software loads two complete table sets through a write port. A symmetric flag picks the set used for each lookup. The bank's group bit picks the first of four DIMMs. A syndrome of -1 marks a multi-bit error. For that case the block reports the whole four-DIMM group instead of a single location. Results that cannot be located are flagged as errors. A lookup is started with a one-cycle strobe and completes with a one-cycle done pulse. The lookups are pipelined, so a new one can start on every cycle.

Top module: `ecc_dimm_locator`

## Requirements
- R1: After a synchronous active-low reset, `res_done`, `res_err`, `res_multi` and `res_dimm_mask` are all 0.
- R2: Each cycle in which `lk_start` is high produces exactly one `res_done` pulse, two rising edges later. Results come out in start order, including when starts arrive on back-to-back cycles.
- R3: A lookup is unknown when `lk_bank_hit` is 0, or when the syndrome is below -1 or above 144. An unknown lookup gives `res_err`=1, `res_multi`=0 and zero on `res_dimm_mask`, `res_dimm`, `res_bit_pos` and `res_pin`.
- R4: The syndrome is converted to bus bit order as follows. Codes 0..127 gain 16. Codes 128..143 lose 137. Codes 144..146 lose 143. Codes of 147 and above lose 147.
- R5: The quadword index q is `lk_addr[5:4]`. The line position is (3-q)*144 plus the converted code, and it is reported on `res_bit_pos`. If that position is negative, the lookup is unknown, as in R3.
- R6: The target bit is 575 minus the line position. The DIMM map byte is entry target/4. Within that byte, pair k = target mod 4 occupies bits [7-2k:6-2k]. Only the lower bit of the pair, bit 6-2k, is used as the DIMM offset. `res_dimm` = 4*`lk_bank_grp` + offset, and `res_dimm_mask` is one-hot at `res_dimm`.
- R7: `res_pin` is pin map entry number (line position).
- R8: `lk_symmetric`=1 selects table set 0, and `lk_symmetric`=0 selects set 1.
- R9: A syndrome of -1 with a bank hit gives `res_multi`=1 and `res_err`=0. It sets mask bits 4*grp through 4*grp+3, gives `res_dimm`=4*grp, and gives 0 on `res_bit_pos` and `res_pin`.
- R10: With `cfg_wr_en` high, `cfg_wr_tbl` (0 = DIMM map, 1 = pin map), `cfg_wr_set` and `cfg_wr_addr` select the entry that takes `cfg_wr_data`. Any lookup that starts after that write sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_tbl | input | 1 | Table choice: 0 DIMM map, 1 pin map |
| cfg_wr_set | input | 1 | Table set to write |
| cfg_wr_addr | input | 10 | Entry index |
| cfg_wr_data | input | 8 | Entry value |
| lk_start | input | 1 | Lookup start strobe |
| lk_syndrome | input | 9 | Signed syndrome code |
| lk_addr | input | 40 | Faulting physical address |
| lk_bank_hit | input | 1 | Address decoded to an enabled bank |
| lk_bank_grp | input | 1 | Group bit of the hit bank |
| lk_symmetric | input | 1 | Map set choice |
| res_done | output | 1 | Result valid pulse |
| res_err | output | 1 | Location unknown |
| res_multi | output | 1 | Multi-bit error, whole group reported |
| res_bit_pos | output | 10 | Position of the failed bit within the line |
| res_dimm | output | 3 | DIMM index |
| res_dimm_mask | output | 8 | Flagged DIMMs |
| res_pin | output | 8 | Pin number from the pin map |

## Verification
On every cycle, the assertions check the result structure. They check the two-edge start-to-done latency. They check that error results carry no flagged DIMM, that a single-bit result flags exactly one DIMM and that DIMM matches `res_dimm`, and that a multi-bit result flags exactly four. They also check that no table read goes past the end of its table and that a reported line position stays within 576. Some behaviour only the bench scenarios can show: the exact syndrome offsets at each range boundary, the negative-position corner for beat 3, the packed pair selection inside a DIMM map byte, set selection by the symmetric flag, and rewritten table entries taking effect. The scoreboard reaches these by comparing full results against a model driven from shadow copies of the tables.

// File: rtl/eccloc_pkg.sv
// Shared constants and types for the ECC syndrome DIMM locator.
// Assumes a 64-byte line carried as four 144-bit beats.
package eccloc_pkg;
    localparam int BEAT_BITS     = 144;
    localparam int BEATS         = 4;
    localparam int LINE_BITS     = BEAT_BITS * BEATS;
    localparam int LINE_BYTES    = 64;
    localparam int BEAT_BYTES    = LINE_BYTES / BEATS;
    localparam int BEAT_LSB      = $clog2(BEAT_BYTES);
    localparam int BEAT_SEL_W    = $clog2(BEATS);
    localparam int PAIRS_PER_B   = 4;
    localparam int DMAP_DEPTH    = LINE_BITS / PAIRS_PER_B;
    localparam int PMAP_DEPTH    = LINE_BITS;
    localparam int POS_W         = $clog2(LINE_BITS);
    localparam int DMAP_AW       = $clog2(DMAP_DEPTH);
    localparam int DMAP_W        = 8;
    localparam int DIMMS_PER_GRP = 4;
    localparam int DIMM_GROUPS   = 2;
    localparam int DIMMS         = DIMMS_PER_GRP * DIMM_GROUPS;
    localparam int DIMM_W        = $clog2(DIMMS);
    localparam int MAP_SETS      = 2;
    localparam int SYN_MULTI     = -1;
    localparam int SYN_MAX       = 144;

    typedef enum logic {
        TBL_DIMM = 1'b0,
        TBL_PIN  = 1'b1
    } map_tbl_e;
endpackage

// File: rtl/eccloc_remap.sv
// Syndrome remap front end (combinational).
// Converts a signed syndrome and a beat index into the line position,
// the DIMM map byte address and the pair slot. It flags codes outside
// the valid range and positions that fall below zero.
// Assumes syn_code is sign-extended two's complement.
module eccloc_remap
    import eccloc_pkg::*;
#(
    parameter int SYN_W = 9
) (
    input  logic signed [SYN_W-1:0]      syn_code,
    input  logic [BEAT_SEL_W-1:0]        beat_idx,
    output logic                         is_multi,
    output logic                         code_bad,
    output logic [POS_W-1:0]             line_pos,
    output logic [DMAP_AW-1:0]           dmap_addr,
    output logic [1:0]                   pair_sel
);
    localparam int CW = ((SYN_W > POS_W) ? SYN_W : POS_W) + 2;
    localparam logic signed [CW-1:0] K_MULTI = CW'(SYN_MULTI);
    localparam logic signed [CW-1:0] K_MAX   = CW'(SYN_MAX);
    localparam logic signed [CW-1:0] K_LO    = CW'(128);
    localparam logic signed [CW-1:0] K_MID   = CW'(144);
    localparam logic signed [CW-1:0] K_HI    = CW'(147);
    localparam logic signed [CW-1:0] K_ZERO  = '0;

    logic signed [CW-1:0] syn_x;
    logic signed [CW-1:0] bus_bit;
    logic signed [CW-1:0] beat_base;
    logic signed [CW-1:0] pos_s;
    logic                 range_bad;
    logic                 pos_bad;
    logic [POS_W-1:0]     tgt_u;

    // Sign extension, range checks and bus-order conversion.
    always_comb begin
        syn_x     = {{(CW-SYN_W){syn_code[SYN_W-1]}}, syn_code};
        is_multi  = (syn_x == K_MULTI);
        range_bad = (syn_x < K_MULTI) || (syn_x > K_MAX);
        if (syn_x < K_LO)
            bus_bit = syn_x + CW'(16);
        else if (syn_x < K_MID)
            bus_bit = syn_x - CW'(137);
        else if (syn_x < K_HI)
            bus_bit = syn_x - CW'(143);
        else
            bus_bit = syn_x - CW'(147);
    end

    // Line position, target bit and table addressing.
    always_comb begin
        beat_base = $signed({{(CW-POS_W){1'b0}},
                             POS_W'((BEATS - 1 - int'(beat_idx)) * BEAT_BITS)});
        pos_s     = beat_base + bus_bit;
        pos_bad   = (pos_s < K_ZERO);
        code_bad  = range_bad | (!is_multi & pos_bad);
        line_pos  = pos_bad ? '0 : pos_s[POS_W-1:0];
        tgt_u     = POS_W'(LINE_BITS - 1) - line_pos;
        dmap_addr = tgt_u[2 +: DMAP_AW];
        pair_sel  = tgt_u[1:0];
    end

    // R5
    always_comb begin
        if (!code_bad && !is_multi) begin
            line_pos_range_chk: assert (int'(line_pos) < LINE_BITS);
        end
    end
endmodule

// File: rtl/eccloc_map_ram.sv
// Map table storage: one synchronous-read, synchronous-write RAM.
// It ignores writes past DEPTH. The read data register clears on reset
// and holds its value when no read is issued.
module eccloc_map_ram #(
    parameter int DEPTH = 144,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    // Table write.
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH))
            mem[wr_addr] <= wr_data;
    end

    // Registered table read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= mem[rd_addr];
    end

    // R7
    rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < DEPTH));
endmodule

// File: rtl/ecc_dimm_locator.sv
// ECC syndrome DIMM locator, top level.
// Stage 1: remap the syndrome and issue reads to the selected table set.
// Stage 2: pick the DIMM offset bit from the packed map byte and register
// the result. Assumes the tables are loaded before any lookup uses them.
module ecc_dimm_locator
    import eccloc_pkg::*;
#(
    parameter int SYN_W  = 9,
    parameter int ADDR_W = 40,
    parameter int PIN_W  = 8,
    localparam int WD_W  = (PIN_W > DMAP_W) ? PIN_W : DMAP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_en,
    input  logic                     cfg_wr_tbl,
    input  logic                     cfg_wr_set,
    input  logic [POS_W-1:0]         cfg_wr_addr,
    input  logic [WD_W-1:0]          cfg_wr_data,
    input  logic                     lk_start,
    input  logic signed [SYN_W-1:0]  lk_syndrome,
    input  logic [ADDR_W-1:0]        lk_addr,
    input  logic                     lk_bank_hit,
    input  logic                     lk_bank_grp,
    input  logic                     lk_symmetric,
    output logic                     res_done,
    output logic                     res_err,
    output logic                     res_multi,
    output logic [POS_W-1:0]         res_bit_pos,
    output logic [DIMM_W-1:0]        res_dimm,
    output logic [DIMMS-1:0]         res_dimm_mask,
    output logic [PIN_W-1:0]         res_pin
);
    localparam int GRP_SHIFT = $clog2(DIMMS_PER_GRP);

    logic                         f_multi;
    logic                         f_bad;
    logic [POS_W-1:0]             f_pos;
    logic [DMAP_AW-1:0]           f_dmap_addr;
    logic [1:0]                   f_pair;
    logic                         set_pick;
    logic                         lk_fail;
    logic                         unused_addr_bits;
    logic [MAP_SETS-1:0][DMAP_W-1:0] dmap_q;
    logic [MAP_SETS-1:0][PIN_W-1:0]  pmap_q;

    logic                 s1_vld;
    logic                 s1_err;
    logic                 s1_multi;
    logic                 s1_grp;
    logic                 s1_set;
    logic [POS_W-1:0]     s1_pos;
    logic [1:0]           s1_pair;

    logic [DMAP_W-1:0]    sel_dmap;
    logic                 off_bit;
    logic [DIMM_W-1:0]    first_dimm;
    logic [DIMM_W-1:0]    hit_dimm;

    assign unused_addr_bits = ^{lk_addr[ADDR_W-1:BEAT_LSB+BEAT_SEL_W],
                                lk_addr[BEAT_LSB-1:0]};
    assign set_pick = ~lk_symmetric;
    assign lk_fail  = f_bad | ~lk_bank_hit;

    eccloc_remap #(.SYN_W(SYN_W)) u_remap (
        .syn_code  (lk_syndrome),
        .beat_idx  (lk_addr[BEAT_LSB +: BEAT_SEL_W]),
        .is_multi  (f_multi),
        .code_bad  (f_bad),
        .line_pos  (f_pos),
        .dmap_addr (f_dmap_addr),
        .pair_sel  (f_pair)
    );

    for (genvar g = 0; g < MAP_SETS; g++) begin : g_set
        logic wr_sel;
        logic rd_sel;
        assign wr_sel = cfg_wr_en && (cfg_wr_set == 1'(g));
        assign rd_sel = lk_start && !lk_fail && !f_multi && (set_pick == 1'(g));

        eccloc_map_ram #(.DEPTH(DMAP_DEPTH), .W(DMAP_W)) u_dmap (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel && (cfg_wr_tbl == TBL_DIMM) &&
                      (int'(cfg_wr_addr) < DMAP_DEPTH)),
            .wr_addr (cfg_wr_addr[DMAP_AW-1:0]),
            .wr_data (cfg_wr_data[DMAP_W-1:0]),
            .rd_en   (rd_sel),
            .rd_addr (f_dmap_addr),
            .rd_data (dmap_q[g])
        );

        eccloc_map_ram #(.DEPTH(PMAP_DEPTH), .W(PIN_W)) u_pmap (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel && (cfg_wr_tbl == TBL_PIN)),
            .wr_addr (cfg_wr_addr),
            .wr_data (cfg_wr_data[PIN_W-1:0]),
            .rd_en   (rd_sel),
            .rd_addr (f_pos),
            .rd_data (pmap_q[g])
        );
    end

    // Stage 1: capture the lookup context alongside the table reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_err   <= 1'b0;
            s1_multi <= 1'b0;
            s1_grp   <= 1'b0;
            s1_set   <= 1'b0;
            s1_pos   <= '0;
            s1_pair  <= '0;
        end else begin
            s1_vld   <= lk_start;
            s1_err   <= lk_fail;
            s1_multi <= f_multi & ~lk_fail;
            s1_grp   <= lk_bank_grp;
            s1_set   <= set_pick;
            s1_pos   <= f_pos;
            s1_pair  <= f_pair;
        end
    end

    // Select the map byte and extract the low bit of the addressed pair.
    always_comb begin
        sel_dmap   = dmap_q[s1_set];
        off_bit    = sel_dmap[{~s1_pair, 1'b0}];
        first_dimm = DIMM_W'(s1_grp) << GRP_SHIFT;
        hit_dimm   = first_dimm + DIMM_W'(off_bit);
    end

    // Stage 2: register the located result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_done      <= 1'b0;
            res_err       <= 1'b0;
            res_multi     <= 1'b0;
            res_bit_pos   <= '0;
            res_dimm      <= '0;
            res_dimm_mask <= '0;
            res_pin       <= '0;
        end else begin
            res_done <= s1_vld;
            if (s1_vld) begin
                res_err   <= s1_err;
                res_multi <= s1_multi;
                if (s1_err) begin
                    res_bit_pos   <= '0;
                    res_dimm      <= '0;
                    res_dimm_mask <= '0;
                    res_pin       <= '0;
                end else if (s1_multi) begin
                    res_bit_pos   <= '0;
                    res_dimm      <= first_dimm;
                    res_dimm_mask <= DIMMS'({DIMMS_PER_GRP{1'b1}}) << first_dimm;
                    res_pin       <= '0;
                end else begin
                    res_bit_pos   <= s1_pos;
                    res_dimm      <= hit_dimm;
                    res_dimm_mask <= DIMMS'(1) << hit_dimm;
                    res_pin       <= pmap_q[s1_set];
                end
            end
        end
    end

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_start |-> ##2 res_done);
    // R2
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> $past(lk_start, 2));
    // R3
    err_no_dimm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_err) |-> (res_dimm_mask == '0 && !res_multi));
    // R6
    single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !res_err && !res_multi) |->
            ($countones(res_dimm_mask) == 1 && res_dimm_mask[res_dimm]));
    // R9
    multi_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_multi) |-> ($countones(res_dimm_mask) == DIMMS_PER_GRP));
    // R5
    bit_pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> (int'(res_bit_pos) < LINE_BITS));
endmodule

// File: tb/ecc_dimm_locator_test.sv
module ecc_dimm_locator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_tbl = 1'b0;
    logic        cfg_wr_set = 1'b0;
    logic [9:0]  cfg_wr_addr = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        lk_start = 1'b0;
    logic signed [8:0] lk_syndrome = '0;
    logic [39:0] lk_addr = '0;
    logic        lk_bank_hit = 1'b0;
    logic        lk_bank_grp = 1'b0;
    logic        lk_symmetric = 1'b0;
    logic        res_done, res_err, res_multi;
    logic [9:0]  res_bit_pos;
    logic [2:0]  res_dimm;
    logic [7:0]  res_dimm_mask;
    logic [7:0]  res_pin;

    ecc_dimm_locator uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_tbl(cfg_wr_tbl), .cfg_wr_set(cfg_wr_set),
        .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .lk_start(lk_start), .lk_syndrome(lk_syndrome), .lk_addr(lk_addr),
        .lk_bank_hit(lk_bank_hit), .lk_bank_grp(lk_bank_grp),
        .lk_symmetric(lk_symmetric),
        .res_done(res_done), .res_err(res_err), .res_multi(res_multi),
        .res_bit_pos(res_bit_pos), .res_dimm(res_dimm),
        .res_dimm_mask(res_dimm_mask), .res_pin(res_pin)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [37:0] vec;
        int          due;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   dm [2][144];
    int   pm [2][576];

    always @(posedge clk) cyc <= cyc + 1;

    // Pack fields: err, multi, pos, dimm, mask, pin.
    function automatic logic [37:0] pack(bit e, bit m, int pos, int d, int mk, int p);
        return {e, m, 10'(pos), 3'(d), 8'(mk), 8'(p)};
    endfunction

    // Expected result built from the requirements and shadow tables.
    function automatic logic [37:0] model(int syn, int off, bit hit, bit grp, bit sym);
        int r, pos, tgt, b, bt, idx, st;
        st = sym ? 0 : 1;
        if (!hit || syn < -1 || syn > 144) return pack(1, 0, 0, 0, 0, 0);
        if (syn == -1) return pack(0, 1, 0, grp * 4, grp ? 8'hF0 : 8'h0F, 0);
        if (syn < 128)      r = syn + 16;
        else if (syn < 144) r = syn - 137;
        else if (syn < 147) r = syn - 143;
        else                r = syn - 147;
        pos = (3 - ((off >> 4) & 3)) * 144 + r;
        if (pos < 0) return pack(1, 0, 0, 0, 0, 0);
        tgt = 575 - pos;
        b   = dm[st][tgt / 4];
        bt  = (b >> (6 - 2 * (tgt % 4))) & 1;
        idx = grp * 4 + bt;
        return pack(0, 0, pos, idx, 1 << idx, pm[st][pos]);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [37:0] act, logic [37:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic wr(bit tbl, bit st, int addr, int data);
        @(negedge clk);
        lk_start    = 1'b0;
        cfg_wr_en   = 1'b1;
        cfg_wr_tbl  = tbl;
        cfg_wr_set  = st;
        cfg_wr_addr = 10'(addr);
        cfg_wr_data = 8'(data);
        if (tbl) pm[st][addr] = data & 255;
        else     dm[st][addr] = data & 255;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            cfg_wr_en = 1'b0;
            lk_start  = 1'b0;
        end
    endtask

    // Driver: start one lookup and push its expected result.
    task automatic issue(int syn, int off, bit hit, bit grp, bit sym, string req);
        exp_t e;
        @(negedge clk);
        cfg_wr_en    = 1'b0;
        lk_start     = 1'b1;
        lk_syndrome  = 9'(syn);
        lk_addr      = 40'h9A_5C30_0000 | 40'(off & 63);
        lk_bank_hit  = hit;
        lk_bank_grp  = grp;
        lk_symmetric = sym;
        e.vec = model(syn, off, hit, grp, sym);
        e.due = cyc + 2;
        e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compare each result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_done) begin
                logic [37:0] act;
                act = {res_err, res_multi, res_bit_pos, res_dimm, res_dimm_mask, res_pin};
                if (q.size() == 0) begin
                    chk(0, "R2", "unexpected done", act, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.due == cyc, "R2", "done latency", 38'(cyc), 38'(e.due));
                    chk(act === e.vec, e.req, "result", act, e.vec);
                end
            end else if (q.size() > 0 && q[0].due < cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(0, "R2", "missing done", 38'(cyc), 38'(e.due));
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!res_done && !res_err && !res_multi && res_dimm_mask == 0, "R1", "reset",
            {res_done, res_err, res_multi, 27'd0, res_dimm_mask}, '0);

        // R10: load both table sets
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 144; i++) wr(0, s[0], i, i * 29 + s * 113 + 7);
            for (int i = 0; i < 576; i++) wr(1, s[0], i, i * 13 + s * 57 + 3);
        end
        idle(2);

        // R4: remap range boundaries
        issue(0,   0,  1, 0, 1, "R4");
        issue(127, 0,  1, 0, 1, "R4");
        issue(128, 0,  1, 1, 1, "R4");
        issue(143, 16, 1, 0, 1, "R4");
        issue(144, 32, 1, 1, 1, "R4");
        idle(3);
        // R5: each beat, plus negative position corner on beat 3
        issue(50,  5,  1, 0, 1, "R5");
        issue(50,  21, 1, 0, 1, "R5");
        issue(50,  40, 1, 1, 1, "R5");
        issue(50,  55, 1, 1, 1, "R5");
        issue(128, 48, 1, 0, 1, "R5");
        issue(136, 48, 1, 0, 1, "R5");
        issue(137, 48, 1, 0, 1, "R5");
        idle(3);
        // R6 R7: pair slots across one map byte
        for (int k = 0; k < 4; k++) issue(100 + k, 0, 1, k[0], 1, "R6");
        issue(77, 16, 1, 1, 0, "R7");
        // R8: same lookup through both sets
        issue(33, 32, 1, 0, 1, "R8");
        issue(33, 32, 1, 0, 0, "R8");
        idle(3);
        // R3: unknown results
        issue(-2,  0, 1, 0, 1, "R3");
        issue(145, 0, 1, 1, 1, "R3");
        issue(200, 0, 1, 0, 0, "R3");
        issue(20,  0, 0, 1, 1, "R3");
        issue(-1,  0, 0, 0, 1, "R3");
        // R9: multi-bit errors in each group
        issue(-1, 16, 1, 0, 1, "R9");
        issue(-1, 48, 1, 1, 0, "R9");
        idle(3);
        // R10: rewrite entries used by a lookup, then repeat it
        issue(10, 0, 1, 0, 1, "R10");
        idle(3);
        wr(0, 0, 29, dm[0][29] ^ 8'hFF);
        wr(1, 0, 458, pm[0][458] ^ 8'h5A);
        issue(10, 0, 1, 0, 1, "R10");
        issue(10, 0, 1, 1, 1, "R10");
        idle(3);
        // R2: back-to-back stream
        for (int k = 0; k < 40; k++)
            issue((k * 37) % 146 - 1, k * 7, 1, k[0], k[1], "R2");
        idle(6);
        chk(q.size() == 0, "R2", "scoreboard drained", 38'(q.size()), '0);
        finish_run();
    end
endmodule